// File: doc/BRIEF.md
# Accumulator and Carry Operate Unit

This block holds the 4-bit accumulator and the 1-bit carry flag of a small 4-bit processor. It updates both from single-byte instructions. When the execute strobe is high on a rising clock edge, the block decodes the 8-bit opcode and writes the new accumulator and carry. The new values are computed from the current state together with a register operand, a 4-bit immediate field or a memory-read nibble.

The supported operations are:
- flag and accumulator housekeeping: clear, set, complement;
- increment and decrement;
- rotate through carry;
- carry-to-accumulator transfers;
- decimal adjust;
- one-hot keyboard conversion;
- register and memory add and subtract with carry;
- loads, the immediate load, and the register exchange.

For the exchange, the block presents the old accumulator value and a write strobe, so the register file outside can store it. Instruction fetch, register storage and memory addressing belong to other blocks.

Top module: `acu_core`

## Requirements
- R1: A synchronous reset (`rst` high on a clock edge) clears the accumulator to 0 and the carry to 0.
- R2: With `exec_en` low, the accumulator and carry keep their values. With `exec_en` high, an opcode outside the list below also leaves both unchanged, for example 0x00, 0x7x, 0xCx, 0xE0-0xE7, 0xEA, 0xFD-0xFF.
- R3: Simple flag and accumulator operations:
  - 0xF0 clears both the accumulator and the carry.
  - 0xF1 clears the carry.
  - 0xFA sets the carry.
  - 0xF3 inverts the carry.
  - 0xF4 inverts every accumulator bit.
- R4: 0xF2 adds 1 to the accumulator, and the carry is 1 only when the value wraps from 15 to 0. 0xF8 subtracts 1, and the carry becomes 1 only if the accumulator was nonzero before.
- R5: 0xF5 rotates the 5-bit value {carry, acc} left: the new carry is acc[3] and the new acc is {acc[2:0], carry}. 0xF6 rotates it right: the new carry is acc[0] and the new acc is {carry, acc[3:1]}.
- R6: 0xF7 puts the carry (0 or 1) into the accumulator and clears the carry. 0xF9 loads 9 when the carry is 1 and 10 when it is 0, then clears the carry.
- R7: 0xFB adds 6 to the accumulator when acc > 9 or the carry is 1. The carry is set if that sum exceeds 15 and is otherwise left as it was. With acc <= 9 and carry 0, nothing changes.
- R8: 0xFC converts the accumulator as follows:
  - 0000 → 0000
  - 0001 → 0001
  - 0010 → 0010
  - 0100 → 0011
  - 1000 → 0100
  - any other value → 1111

  The carry is unchanged.
- R9: 0x8r sets {carry, acc} to acc + reg_val + carry.
- R10: 0x9r sets {carry, acc} to acc + ~reg_val + carry. A resulting carry of 1 means no borrow.
- R11: 0xAr loads `reg_val` into the accumulator. 0xDd loads `imm_val`. The carry is unchanged for both.
- R12: 0xBr loads `reg_val` into the accumulator, carry unchanged. During that cycle `reg_wr_en` is high and `reg_wr_data` carries the accumulator value held before the edge. `reg_wr_en` is low for every other opcode and whenever `exec_en` is low.
- R13: Memory operations:
  - 0xE9 loads `mem_val` into the accumulator.
  - 0xEB adds `mem_val` with carry, as in R9.
  - 0xE8 subtracts `mem_val` with carry, as in R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Execute strobe; state updates only when high |
| opcode | input | 8 | Instruction byte |
| reg_val | input | 4 | Register operand selected by the opcode |
| imm_val | input | 4 | Immediate nibble |
| mem_val | input | 4 | Memory-read nibble |
| acc | output | 4 | Current accumulator |
| cy | output | 1 | Current carry flag |
| reg_wr_en | output | 1 | Exchange write-back strobe to the register file |
| reg_wr_data | output | 4 | Value to store in the register on exchange |

## Verification
Every accumulator-group opcode is applied from all 32 combinations of accumulator and carry. This separates the carry-dependent paths from the value-dependent ones, such as the decimal-adjust trigger, the rotate bit moves and the keyboard codes that are not one-hot.

Register and memory add and subtract are swept over every operand against every state. This covers wrap, carry-in, and the no-borrow meaning of the carry.

Idle cycles, opcodes outside the map, and the exchange strobe are each checked at the outputs, so a decode that leaks into a neighbouring opcode range shows up.

// File: rtl/acu_pkg.sv
package acu_pkg;
  localparam int DW = 4;
  localparam int OPW = 8;

  typedef enum logic [4:0] {
    K_NONE, K_CLB, K_CLC, K_IAC, K_CMC, K_CMA, K_RAL, K_RAR, K_TCC,
    K_DAC, K_TCS, K_STC, K_DAA, K_KBP, K_ADD, K_SUB, K_LD, K_XCH,
    K_LDM, K_SBM, K_RDM, K_ADM
  } kind_e;

  // 4-bit add with carry-in, returns {carry_out, sum}
  function automatic logic [DW:0] add_ci(logic [DW-1:0] a, logic [DW-1:0] b, logic ci);
    return {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, ci};
  endfunction

  // one-hot nibble to index, illegal -> all ones
  function automatic logic [DW-1:0] onehot_idx(logic [DW-1:0] a);
    logic [DW-1:0] r;
    r = '1;
    if (a == '0) r = '0;
    for (int i = 0; i < DW; i++)
      if (a == (DW'(1) << i)) r = DW'(i + 1);
    return r;
  endfunction

  // decimal adjust: returns {carry, acc}
  function automatic logic [DW:0] dec_adj(logic [DW-1:0] a, logic c);
    logic [DW:0] s;
    s = {c, a};
    if (a > DW'(9) || c) begin
      s = {1'b0, a} + (DW+1)'(6);
      s[DW] = s[DW] | c;
    end
    return s;
  endfunction
endpackage

// File: rtl/acu_decode.sv
module acu_decode
  import acu_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output kind_e          kind
);
  always_comb begin
    kind = K_NONE;
    unique case (opcode[7:4])
      4'h8: kind = K_ADD;
      4'h9: kind = K_SUB;
      4'hA: kind = K_LD;
      4'hB: kind = K_XCH;
      4'hD: kind = K_LDM;
      4'hE: begin
        case (opcode[3:0])
          4'h8: kind = K_SBM;
          4'h9: kind = K_RDM;
          4'hB: kind = K_ADM;
          default: kind = K_NONE;
        endcase
      end
      4'hF: begin
        case (opcode[3:0])
          4'h0: kind = K_CLB;
          4'h1: kind = K_CLC;
          4'h2: kind = K_IAC;
          4'h3: kind = K_CMC;
          4'h4: kind = K_CMA;
          4'h5: kind = K_RAL;
          4'h6: kind = K_RAR;
          4'h7: kind = K_TCC;
          4'h8: kind = K_DAC;
          4'h9: kind = K_TCS;
          4'hA: kind = K_STC;
          4'hB: kind = K_DAA;
          4'hC: kind = K_KBP;
          default: kind = K_NONE;
        endcase
      end
      default: kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/acu_alu.sv
module acu_alu
  import acu_pkg::*;
(
  input  kind_e          kind,
  input  logic [DW-1:0]  acc_q,
  input  logic           cy_q,
  input  logic [DW-1:0]  reg_val,
  input  logic [DW-1:0]  imm_val,
  input  logic [DW-1:0]  mem_val,
  output logic [DW-1:0]  acc_nxt,
  output logic           cy_nxt
);
  logic [DW:0] sum_w;
  logic [DW-1:0] opnd_w;
  logic          inv_w;

  // shared adder: operand and inversion chosen per kind
  always_comb begin
    inv_w  = (kind == K_SUB) || (kind == K_SBM);
    opnd_w = (kind == K_ADM || kind == K_SBM) ? mem_val : reg_val;
    sum_w  = add_ci(acc_q, inv_w ? ~opnd_w : opnd_w, cy_q);
  end

  always_comb begin
    acc_nxt = acc_q;
    cy_nxt  = cy_q;
    case (kind)
      K_CLB: begin acc_nxt = '0; cy_nxt = 1'b0; end
      K_CLC: cy_nxt = 1'b0;
      K_STC: cy_nxt = 1'b1;
      K_CMC: cy_nxt = ~cy_q;
      K_CMA: acc_nxt = ~acc_q;
      K_IAC: {cy_nxt, acc_nxt} = add_ci(acc_q, '0, 1'b1);
      K_DAC: {cy_nxt, acc_nxt} = add_ci(acc_q, '1, 1'b0);
      K_RAL: {cy_nxt, acc_nxt} = {acc_q, cy_q};
      K_RAR: {acc_nxt, cy_nxt} = {cy_q, acc_q};
      K_TCC: begin acc_nxt = {{(DW-1){1'b0}}, cy_q}; cy_nxt = 1'b0; end
      K_TCS: begin acc_nxt = cy_q ? DW'(9) : DW'(10); cy_nxt = 1'b0; end
      K_DAA: {cy_nxt, acc_nxt} = dec_adj(acc_q, cy_q);
      K_KBP: acc_nxt = onehot_idx(acc_q);
      K_ADD, K_SUB, K_ADM, K_SBM: {cy_nxt, acc_nxt} = sum_w;
      K_LD, K_XCH: acc_nxt = reg_val;
      K_LDM: acc_nxt = imm_val;
      K_RDM: acc_nxt = mem_val;
      default: ;
    endcase
  end
endmodule

// File: rtl/acu_core.sv
module acu_core
  import acu_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           exec_en,
  input  logic [OPW-1:0] opcode,
  input  logic [DW-1:0]  reg_val,
  input  logic [DW-1:0]  imm_val,
  input  logic [DW-1:0]  mem_val,
  output logic [DW-1:0]  acc,
  output logic           cy,
  output logic           reg_wr_en,
  output logic [DW-1:0]  reg_wr_data
);
  kind_e         kind_w;
  logic [DW-1:0] acc_q, acc_nxt_w;
  logic          cy_q, cy_nxt_w;
  logic          op_fire_w;

  acu_decode u_dec (.opcode(opcode), .kind(kind_w));

  acu_alu u_alu (
    .kind(kind_w), .acc_q(acc_q), .cy_q(cy_q),
    .reg_val(reg_val), .imm_val(imm_val), .mem_val(mem_val),
    .acc_nxt(acc_nxt_w), .cy_nxt(cy_nxt_w)
  );

  assign op_fire_w = exec_en && (kind_w != K_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
    end else if (op_fire_w) begin
      acc_q <= acc_nxt_w;
      cy_q  <= cy_nxt_w;
    end
  end

  assign acc         = acc_q;
  assign cy          = cy_q;
  assign reg_wr_en   = exec_en && (kind_w == K_XCH);
  assign reg_wr_data = acc_q;

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (acc == '0 && !cy)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> ($stable(acc) && $stable(cy))); // R2
  AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (rst)
    (exec_en && opcode == 8'hF0) |=> (acc == '0 && !cy)); // R3
  AST_CMC_FLIP: assert property (@(posedge clk) disable iff (rst)
    (exec_en && opcode == 8'hF3) |=> (cy != $past(cy))); // R3
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (exec_en && opcode == 8'hF2 && acc == 4'hF) |=> (acc == '0 && cy)); // R4
  AST_TCC_MOVE: assert property (@(posedge clk) disable iff (rst)
    (exec_en && opcode == 8'hF7) |=> (acc == {3'b000, $past(cy)} && !cy)); // R6
  AST_DAA_QUIET: assert property (@(posedge clk) disable iff (rst)
    (exec_en && opcode == 8'hFB && !cy && acc <= 4'd9) |=> ($stable(acc) && !cy)); // R7
  AST_KBP_BAD: assert property (@(posedge clk) disable iff (rst)
    (exec_en && opcode == 8'hFC && !$onehot0(acc)) |=> (acc == 4'hF)); // R8
  AST_XCH_TAKE: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> (acc == $past(reg_val) && cy == $past(cy))); // R12
endmodule

// File: tb/sim_acu_core.sv
module sim_acu_core;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, exec_en = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [3:0] reg_val = '0, imm_val = '0, mem_val = '0;
  logic [3:0] acc, reg_wr_data;
  logic cy, reg_wr_en;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acu_core u0 (.clk(clk), .rst(rst), .exec_en(exec_en), .opcode(opcode),
    .reg_val(reg_val), .imm_val(imm_val), .mem_val(mem_val), .acc(acc), .cy(cy),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data));

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // integer reference of one instruction
  task automatic ref_op(input int op, input int a, input int c, input int r,
                        input int im, input int m, output int na, output int nc);
    int s;
    na = a; nc = c;
    case (op / 16)
      8:  begin s = a + r + c; na = s % 16; nc = s / 16; end
      9:  begin s = a + (15 - r) + c; na = s % 16; nc = s / 16; end
      10, 11: na = r;
      13: na = im;
      default: ;
    endcase
    case (op)
      'hE8: begin s = a + (15 - m) + c; na = s % 16; nc = s / 16; end
      'hE9: na = m;
      'hEB: begin s = a + m + c; na = s % 16; nc = s / 16; end
      'hF0: begin na = 0; nc = 0; end
      'hF1: nc = 0;
      'hF2: begin s = a + 1; na = s % 16; nc = s / 16; end
      'hF3: nc = 1 - c;
      'hF4: na = 15 - a;
      'hF5: begin na = (a * 2 + c) % 16; nc = a / 8; end
      'hF6: begin na = a / 2 + 8 * c; nc = a % 2; end
      'hF7: begin na = c; nc = 0; end
      'hF8: begin na = (a + 15) % 16; nc = (a != 0) ? 1 : 0; end
      'hF9: begin na = (c == 1) ? 9 : 10; nc = 0; end
      'hFA: nc = 1;
      'hFB: if (a > 9 || c == 1) begin s = a + 6; na = s % 16; if (s > 15) nc = 1; end
      'hFC: case (a)
              0: na = 0; 1: na = 1; 2: na = 2; 4: na = 3; 8: na = 4;
              default: na = 15;
            endcase
      default: ;
    endcase
  endtask

  task automatic issue(input int op, input int r, input int im, input int m);
    @(negedge clk);
    opcode = 8'(op); reg_val = 4'(r); imm_val = 4'(im); mem_val = 4'(m);
    exec_en = 1'b1;
    @(negedge clk);
    exec_en = 1'b0;
  endtask

  task automatic set_state(input int a, input int c);
    issue('hD0, 0, a, 0);
    issue(c ? 'hFA : 'hF1, 0, 0, 0);
  endtask

  task automatic sweep_op(input string req, input int op, input int r_lo, input int r_hi);
    int na, nc;
    for (int a = 0; a < 16; a++)
      for (int c = 0; c < 2; c++)
        for (int r = r_lo; r <= r_hi; r++) begin
          set_state(a, c);
          ref_op(op, a, c, r, r ^ 5, r, na, nc);
          issue(op, r, r ^ 5, r);
          check(req, acc, na);
          check(req, cy, nc);
        end
  endtask

  task automatic t_reset;
    set_state(11, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 acc", acc, 0);
    check("R1 cy", cy, 0);
  endtask

  task automatic t_ignore;
    int bad[8] = '{'h00, 'h7A, 'hC5, 'hE0, 'hE7, 'hEA, 'hFD, 'hFF};
    set_state(6, 1);
    @(negedge clk); opcode = 8'hF4; exec_en = 1'b0;
    @(negedge clk);
    check("R2 idle acc", acc, 6); check("R2 idle cy", cy, 1);
    foreach (bad[i]) begin
      issue(bad[i], 3, 9, 12);
      check("R2 unmapped acc", acc, 6);
      check("R2 unmapped cy", cy, 1);
    end
  endtask

  task automatic t_flags;
    sweep_op("R3 F0", 'hF0, 0, 0); sweep_op("R3 F1", 'hF1, 0, 0);
    sweep_op("R3 FA", 'hFA, 0, 0); sweep_op("R3 F3", 'hF3, 0, 0);
    sweep_op("R3 F4", 'hF4, 0, 0);
  endtask

  task automatic t_incdec;  sweep_op("R4 F2", 'hF2, 0, 0); sweep_op("R4 F8", 'hF8, 0, 0); endtask
  task automatic t_rotate;  sweep_op("R5 F5", 'hF5, 0, 0); sweep_op("R5 F6", 'hF6, 0, 0); endtask
  task automatic t_transfer; sweep_op("R6 F7", 'hF7, 0, 0); sweep_op("R6 F9", 'hF9, 0, 0); endtask
  task automatic t_daa;     sweep_op("R7 FB", 'hFB, 0, 0); endtask
  task automatic t_kbp;     sweep_op("R8 FC", 'hFC, 0, 0); endtask
  task automatic t_add;     sweep_op("R9 add", 'h83, 0, 15); endtask
  task automatic t_sub;     sweep_op("R10 sub", 'h9C, 0, 15); endtask
  task automatic t_load;    sweep_op("R11 ld", 'hA1, 0, 15); sweep_op("R11 ldm", 'hD7, 0, 15); endtask
  task automatic t_mem;
    sweep_op("R13 rdm", 'hE9, 0, 15); sweep_op("R13 adm", 'hEB, 0, 15);
    sweep_op("R13 sbm", 'hE8, 0, 15);
  endtask

  task automatic t_xchg;
    set_state(13, 1);
    @(negedge clk);
    opcode = 8'hB4; reg_val = 4'd2; exec_en = 1'b1;
    #1;
    check("R12 wr_en", reg_wr_en, 1);
    check("R12 wr_data", reg_wr_data, 13);
    @(negedge clk); exec_en = 1'b0;
    #1;
    check("R12 wr_en idle", reg_wr_en, 0);
    check("R12 acc", acc, 2); check("R12 cy", cy, 1);
    opcode = 8'hA4; exec_en = 1'b1; #1;
    check("R12 wr_en other op", reg_wr_en, 0);
    @(negedge clk); exec_en = 1'b0;
    sweep_op("R12 xch", 'hB9, 0, 15);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 acc at reset", acc, 0);
    check("R1 cy at reset", cy, 0);
    t_reset(); t_ignore(); t_flags(); t_incdec(); t_rotate(); t_transfer();
    t_daa(); t_kbp(); t_add(); t_sub(); t_load(); t_xchg(); t_mem();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule